// File: doc/BRIEF.md
# SPI Master with Single-Entry Transmit Buffer

This block is a byte-wide SPI master placed behind a small register port. Software selects the clock polarity, the clock phase and a 3-bit rate code in a control register. It then writes a byte to the data register, and that write starts a transfer. The block shifts the byte out most significant bit first on `mosi` and shifts the same number of bits in from `miso`. It drives `sck` from a divided system clock and holds `cs_n` low for the whole byte.

The transmit side holds one byte. A byte written while a transfer is running waits in the buffer and starts its own transfer one clock after the current one finishes. When the last bit is done, the received byte lands in the receive buffer on the same clock that the busy flag drops, and a sticky pending bit is set. That bit raises `irq` only when the interrupt enable is set. The clock format and the rate are captured when a byte is loaded into the shifter, so software may change them between transfers without disturbing the one in flight.

Top module: `spim_master`

## Requirements
- R1: The `sck` half-period is 2^RATE system clocks, so the full period is 2^(RATE+1) clocks (/2 to /256). RATE is control bits [2:0]. The first `sck` edge comes 2^RATE clocks after the byte is loaded.
- R2: While no transfer runs, `cs_n` is 1 and `sck` sits at the polarity bit (control bit 4). During a transfer `cs_n` is 0.
- R3: Every transfer has 16 `sck` edges and moves 8 bits MSB first. With phase bit (control bit 3) at 0, data is sampled on leading edges and changes on trailing edges. With it at 1, data changes on leading edges and is sampled on trailing edges.
- R4: A write to the data register (address 1) starts a transfer. Transmit-full (status bit 1) reads 1 on the clock after the write. It returns to 0 when the byte moves into the shifter, one clock later if the shifter is idle.
- R5: Busy (status bit 0) reads 1 from the load until the last bit. The received byte is readable at address 1 from the same clock that busy returns to 0.
- R6: Each completion sets the pending bit (status bit 2). `irq` equals pending AND enable (control bit 5). Writing status with bit 2 at 1 clears pending. Writing it with bit 2 at 0 leaves pending unchanged.
- R7: A data write during a transfer is held with status reading 3 (full and busy). That byte starts its transfer one clock after the running one completes.
- R8: Control writes made during a transfer do not affect that transfer's rate or format.
- R9: The register map is address 0 control, 1 data, 2 status, 3 reserved. Status bits [7:3], control read bits [7:6] and all of address 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Completion interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Slave select, active low |

## Verification
A wrong edge counter or wrong shifter state shows up within the same transfer. The slave model would see an edge count other than 16, or a MOSI byte that differs from the written one, when `cs_n` rises. It would also read back a byte that differs from the one it drove. A divider fault shows up at the first `sck` edge as a wrong spacing in clocks. A fault in the buffer or flag logic shows up in the status read taken one clock after a data write, or as a missing second transfer when two bytes are queued.

// File: rtl/spim_pkg.sv
// Shared constants and types for the SPI master.
// Assumes a 2-bit register address space and an 8-bit register port.
package spim_pkg;
    localparam int SPIM_RATE_W = 3;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // Transfer configuration held in the control register.
    typedef struct packed {
        logic                   ien;
        logic                   cpol;
        logic                   cpha;
        logic [SPIM_RATE_W-1:0] rate;
    } spim_cfg_t;
endpackage

// File: rtl/spim_rate_div.sv
// Divider producing one-clock ticks at each SCK half-period.
// A tick comes every 2^rate clocks while en is high. clr restarts the count.
// Assumes rate is stable while en is high.
module spim_rate_div #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int CW = (1 << RATE_W) - 1;

    logic [CW-1:0] cnt;
    logic [CW:0]   span;
    logic [CW-1:0] lim;

    // Terminal count for the selected rate.
    always_comb begin
        span = (CW+1)'(1) << rate;
        lim  = CW'(span - 1'b1);
    end

    assign tick = en && (cnt == lim);

    // Count clocks inside the half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= tick ? '0 : cnt + 1'b1;
        end
    end

    // R1: the count never runs past the terminal value.
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> cnt <= lim);
endmodule

// File: rtl/spim_engine.sv
// Shift engine for a single byte transfer.
// On start it captures the byte and the configuration, then runs 2*DATA_W
// SCK edges. It shifts MSB first, samples on the edges the phase selects and
// pulses done on the last edge with rx_o valid in that cycle.
// Assumes start is asserted only while run_o is low.
module spim_engine
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  spim_cfg_t         cfg_i,
    input  logic              miso,
    output logic              run_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o,
    output logic              sck_o,
    output logic              mosi_o
);
    localparam int EW = $clog2(2 * DATA_W);
    localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DATA_W - 1);

    spim_cfg_t         cfg_q;
    logic              run;
    logic [EW-1:0]     ecnt;
    logic [DATA_W-1:0] tsr;
    logic [DATA_W-1:0] rsr;
    logic              sck_q;
    logic              tick;
    logic              last;
    logic              sample_now;
    logic              shift_now;
    logic [DATA_W-1:0] rsr_nx;

    spim_rate_div #(.RATE_W(SPIM_RATE_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .en    (run),
        .rate  (cfg_q.rate),
        .tick  (tick)
    );

    // Edge classification: even edge count is a leading edge.
    always_comb begin
        last       = (ecnt == LAST_EDGE);
        sample_now = run && tick && (cfg_q.cpha ? ecnt[0] : ~ecnt[0]);
        shift_now  = run && tick && (cfg_q.cpha ? (~ecnt[0] && ecnt != '0)
                                                : (ecnt[0] && !last));
        rsr_nx     = sample_now ? {rsr[DATA_W-2:0], miso} : rsr;
    end

    // Transfer sequencing, SCK toggling and both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            run   <= 1'b0;
            ecnt  <= '0;
            tsr   <= '0;
            rsr   <= '0;
            sck_q <= 1'b0;
        end else if (start) begin
            cfg_q <= cfg_i;
            run   <= 1'b1;
            ecnt  <= '0;
            tsr   <= tx_byte;
            rsr   <= '0;
            sck_q <= cfg_i.cpol;
        end else if (run && tick) begin
            sck_q <= ~sck_q;
            ecnt  <= ecnt + 1'b1;
            rsr   <= rsr_nx;
            if (shift_now) tsr <= {tsr[DATA_W-2:0], 1'b0};
            if (last) run <= 1'b0;
        end
    end

    assign run_o  = run;
    assign done_o = run && tick && last;
    assign rx_o   = rsr_nx;
    assign sck_o  = run ? sck_q : cfg_i.cpol;
    assign mosi_o = tsr[DATA_W-1];

    // R3: an even number of edges brings SCK back to the captured polarity.
    a_r3_sck_returns: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> sck_q == cfg_q.cpol);

    // R8: the captured configuration holds for the whole transfer.
    a_r8_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && !$past(start) |-> $stable(cfg_q));
endmodule

// File: rtl/spim_master.sv
// Register-mapped SPI master (top level).
// Holds the control, transmit, receive and pending state and decodes the
// register port. It hands bytes to the shift engine one at a time.
// Assumes bus_wr is a single-clock strobe and reads have no side effects.
module spim_master
    import spim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int CFG_W = $bits(spim_cfg_t);

    spim_cfg_t         ctrl_q;
    logic [DATA_W-1:0] tx_q;
    logic              tx_full;
    logic [DATA_W-1:0] rx_q;
    logic              pend;
    logic              wr_ctrl, wr_data, wr_stat;
    logic              start;
    logic              busy;
    logic              done;
    logic [DATA_W-1:0] eng_rx;

    // Register write decode.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
        wr_data = bus_wr && (bus_addr == ADDR_DATA);
        wr_stat = bus_wr && (bus_addr == ADDR_STAT);
        start   = tx_full && !busy;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= spim_cfg_t'(bus_wdata[CFG_W-1:0]);
    end

    // Transmit buffer and its full flag; a new write wins over a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            tx_full <= 1'b0;
        end else if (wr_data) begin
            tx_q    <= bus_wdata;
            tx_full <= 1'b1;
        end else if (start) begin
            tx_full <= 1'b0;
        end
    end

    // Receive buffer, loaded on the completing edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_q <= '0;
        else if (done) rx_q <= eng_rx;
    end

    // Sticky completion flag, cleared by writing 1; a completion wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                    pend <= 1'b0;
        else if (done)                 pend <= 1'b1;
        else if (wr_stat && bus_wdata[2]) pend <= 1'b0;
    end

    spim_engine #(.DATA_W(DATA_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_byte (tx_q),
        .cfg_i   (ctrl_q),
        .miso    (miso),
        .run_o   (busy),
        .done_o  (done),
        .rx_o    (eng_rx),
        .sck_o   (sck),
        .mosi_o  (mosi)
    );

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: bus_rdata[CFG_W-1:0] = ctrl_q;
            ADDR_DATA: bus_rdata = rx_q;
            ADDR_STAT: bus_rdata[2:0] = {pend, tx_full, busy};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq  = pend && ctrl_q.ien;
    assign cs_n = !busy;

    // R2: idle SCK follows the programmed polarity.
    a_r2_idle_sck: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sck == ctrl_q.cpol);

    // R4: the load empties the buffer unless a new byte arrived that clock.
    a_r4_full_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && !$past(wr_data) |-> !tx_full);

    // R5: completion and the pending flag land on the same clock.
    a_r5_done_pend: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> pend);

    // R6: the request never fires with the enable off.
    a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctrl_q.ien);

    // R7: a held byte starts one clock after completion.
    a_r7_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && tx_full |=> busy);
endmodule

// File: tb/spim_master_bench.sv
// Scoreboard bench: the driver queues expected MOSI bytes, and the slave
// monitor pops and compares them when cs_n rises.
module spim_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq, sck, mosi, cs_n;
    logic       miso;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q[$];
    logic [7:0] sl_q[$];

    int   m_rate = 0;
    logic m_cpol = 1'b0;
    logic m_cpha = 1'b0;

    logic [7:0] sl_sh = 8'h00;
    logic [7:0] sl_rx = 8'h00;
    int   edges = 0;
    int   gap = 0;
    logic prev_sck = 1'b0;
    logic prev_cs = 1'b1;

    assign miso = sl_sh[7];

    spim_master u_spim_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Slave model and monitor, evaluated between clock edges.
    always @(negedge clk) begin
        if (rst_n) begin
            gap++;
            if (prev_cs && !cs_n) begin
                sl_sh = (sl_q.size() > 0) ? sl_q.pop_front() : 8'h00;
                sl_rx = 8'h00;
                edges = 0;
                gap   = 0;
            end else if ((sck !== prev_sck) && !prev_cs) begin
                check("R1 sck edge spacing", gap, 1 << m_rate);
                gap = 0;
                if (m_cpha ? (edges % 2 == 1) : (edges % 2 == 0))
                    sl_rx = {sl_rx[6:0], mosi};
                if (m_cpha ? (edges % 2 == 0 && edges != 0)
                           : (edges % 2 == 1 && edges != 15))
                    sl_sh = {sl_sh[6:0], 1'b0};
                edges++;
            end
            if (!prev_cs && cs_n) begin
                check("R3 edge count", edges, 16);
                if (exp_q.size() == 0) check("R3 unexpected transfer", 1, 0);
                else check("R3 mosi byte", sl_rx, exp_q.pop_front());
            end
            prev_sck = sck;
            prev_cs  = cs_n;
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    task automatic wait_quiet();
        logic [7:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd_reg(2'd2, s);
            if (s[1:0] == 2'b00) return;
        end
        check("R5 transfer never finished", 1, 0);
    endtask

    task automatic set_mode(input int rate, input logic cpol, input logic cpha,
                            input logic ien);
        m_rate = rate; m_cpol = cpol; m_cpha = cpha;
        wr_reg(2'd0, {2'b00, ien, cpol, cpha, 3'(rate)});
    endtask

    task automatic xfer(input int rate, input logic cpol, input logic cpha,
                        input logic ien, input logic [7:0] tx, input logic [7:0] sb);
        logic [7:0] d;
        set_mode(rate, cpol, cpha, ien);
        @(negedge clk); #1;
        check("R2 idle sck", sck, cpol);
        check("R2 idle cs_n", cs_n, 1);
        sl_q.push_back(sb);
        exp_q.push_back(tx);
        wr_reg(2'd1, tx);
        peek(2'd2, d);
        check("R4 full after write", d, 8'h02);
        rd_reg(2'd2, d);
        check("R4 loaded, R5 busy", d, 8'h01);
        check("R2 cs_n low", cs_n, 0);
        wait_quiet();
        peek(2'd2, d);
        check("R6 pending set", d, 8'h04);
        check("R6 irq gating", irq, ien);
        peek(2'd1, d);
        check("R5 rx byte", d, sb);
        wr_reg(2'd2, 8'h00);
        peek(2'd2, d);
        check("R6 write 0 keeps pending", d, 8'h04);
        wr_reg(2'd2, 8'h04);
        peek(2'd2, d);
        check("R6 write 1 clears", d, 8'h00);
        check("R6 irq low", irq, 0);
    endtask

    initial begin
        #(8 * 150000);
        check("watchdog", 1, 0);
        summary();
    end

    initial begin
        logic [7:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // Reset state and register map (R9).
        rd_reg(2'd2, d); check("R9 reset status", d, 8'h00);
        peek(2'd0, d);   check("R9 reset control", d, 8'h00);
        check("R2 reset cs_n", cs_n, 1);
        check("R6 reset irq", irq, 0);
        peek(2'd3, d);   check("R9 reserved address", d, 8'h00);
        wr_reg(2'd0, 8'hFF);
        peek(2'd0, d);   check("R9 control upper bits", d, 8'h3F);

        // All four formats at several rates (R1, R3).
        xfer(0, 1'b0, 1'b0, 1'b1, 8'hA5, 8'h3C);
        xfer(1, 1'b0, 1'b1, 1'b0, 8'h81, 8'h7E);
        xfer(2, 1'b1, 1'b0, 1'b1, 8'h5A, 8'hC3);
        xfer(3, 1'b1, 1'b1, 1'b1, 8'h01, 8'h80);
        xfer(7, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00);
        xfer(5, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF);

        // Held byte starts right after the first (R7).
        set_mode(1, 1'b0, 1'b0, 1'b1);
        sl_q.push_back(8'h11); sl_q.push_back(8'h99);
        exp_q.push_back(8'hC6); exp_q.push_back(8'h2B);
        wr_reg(2'd1, 8'hC6);
        rd_reg(2'd2, d); check("R4 first loaded", d, 8'h01);
        wr_reg(2'd1, 8'h2B);
        peek(2'd2, d);   check("R7 held while busy", d, 8'h03);
        wait_quiet();
        peek(2'd1, d);   check("R7 second rx byte", d, 8'h99);
        check("R7 both bytes sent", exp_q.size(), 0);
        wr_reg(2'd2, 8'h04);

        // Control change mid-transfer has no effect (R8).
        set_mode(2, 1'b0, 1'b1, 1'b0);
        sl_q.push_back(8'h6D); exp_q.push_back(8'hB4);
        wr_reg(2'd1, 8'hB4);
        wr_reg(2'd0, 8'h00);
        wait_quiet();
        peek(2'd1, d);   check("R8 rx with captured format", d, 8'h6D);
        check("R8 byte sent", exp_q.size(), 0);
        wr_reg(2'd2, 8'h04);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule